// File: doc/BRIEF.md
# Full-Frames-First Input Spreading Scheduler

This block sits on the input side of one linecard in a two-stage load-balanced switch. Arriving cells are sorted by destination into one FIFO per destination flow. Time is split into frames of N slots. At the first slot of each frame the scheduler picks one flow and keeps it for the whole frame. A flow holding at least N cells always beats a flow holding fewer. The chosen flow's cells go out one per slot, each to the next middle port in that flow's own rotation.

Because a flow's cells land on consecutive middle ports, and whole frames are sent whenever possible, the output side of the switch can put each flow back in order. The block emits at most one cell per slot, together with its destination and the middle port it must cross. When a FIFO is full, the block refuses new cells for that destination by dropping its ready signal.

Top module: `ffs_spreader`

## Requirements
- R1: `slot_idx` is 0 in the first cycle after reset, then counts 0,1,...,N-1 and wraps to 0. A frame starts in every cycle where it is 0.
- R2: The cells of one flow leave in the order they arrived. Each one leaves with `out_dest` equal to the destination it was written with.
- R3: `in_ready` is low exactly when the FIFO for `in_dest` already holds DEPTH cells. A cell offered while `in_ready` is low is discarded and never appears at the output.
- R4: At slot 0, occupancy is counted before that cycle's arrival. If any flow holds N or more cells, the chosen flow is the first such flow found from the round-robin pointer upward, wrapping past N-1. It sends N cells in slots 0 to N-1.
- R5: If no flow holds N cells, the chosen flow is the first non-empty flow from the round-robin pointer upward. It sends all k of its cells (k below N) in slots 0 to k-1, and slots k to N-1 stay idle. If every FIFO is empty, the whole frame is idle.
- R6: The round-robin pointer is 0 after reset. After each non-idle selection it becomes the chosen flow plus one, modulo N, and an idle frame leaves it unchanged.
- R7: Each flow has a middle-port pointer that is 0 after reset. A cell is sent with `out_port` equal to its flow's pointer, and the pointer then advances by one modulo N. It advances only when a cell is actually sent.
- R8: At most one cell leaves per slot. Within a frame every valid cell carries the same `out_dest`, and valid slots are contiguous from slot 0.
- R9: During and right after reset `out_valid` is low, `slot_idx` is 0, every FIFO is empty and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arriving cell present |
| in_dest | input | $clog2(N) | Destination flow of the arriving cell |
| in_data | input | DATA_W | Arriving cell payload |
| in_ready | output | 1 | FIFO of `in_dest` can accept a cell |
| slot_idx | output | $clog2(N) | Current slot within the frame |
| out_valid | output | 1 | A cell is sent this slot |
| out_data | output | DATA_W | Payload of the sent cell |
| out_dest | output | $clog2(N) | Destination flow of the sent cell |
| out_port | output | $clog2(N) | Middle port the cell is sent to |

## Verification
The bench builds the block with N=4, DEPTH=6 and DATA_W=8. At this size a few thousand slots of random traffic reach every case: full and partial frames, idle frames, ties between several full flows at every pointer position, each port-pointer phase, and FIFOs at capacity where cells are refused. Arrival rates and destination skew change between phases, so the FIFOs are sometimes held near full and sometimes drained to empty. Every slot is compared against a bench-side model of the queues and pointers.

// File: rtl/ffs_spreader.sv
module ffs_spreader #(
  parameter int N      = 4,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [$clog2(N)-1:0] in_dest,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [$clog2(N)-1:0] slot_idx,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [$clog2(N)-1:0] out_dest,
  output logic [$clog2(N)-1:0] out_port
);
  localparam int FW = $clog2(N);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int KW = $clog2(N + 1);

  logic [DATA_W-1:0] mem [N][DEPTH];
  logic [AW-1:0]     wr_q [N];
  logic [AW-1:0]     rd_q [N];
  logic [CW-1:0]     fcount [N];
  logic [FW-1:0]     port_q [N];
  logic [FW-1:0]     slot_q, rr_q, sel_q;
  logic [KW-1:0]     k_q;

  logic          full_hit, part_hit;
  logic [FW-1:0] full_idx, part_idx, idx;
  logic [FW-1:0] pick_sel, cur_sel;
  logic [KW-1:0] pick_k, cur_k;
  logic [N-1:0]  push_v, pop_v;

  always_comb begin
    full_hit = 1'b0;
    part_hit = 1'b0;
    full_idx = '0;
    part_idx = '0;
    idx      = '0;
    for (int j = 0; j < N; j++) begin
      idx = FW'((int'(rr_q) + j) % N);
      if (!full_hit && int'(fcount[idx]) >= N) begin
        full_hit = 1'b1;
        full_idx = idx;
      end
      if (!part_hit && fcount[idx] != '0) begin
        part_hit = 1'b1;
        part_idx = idx;
      end
    end
  end

  assign pick_sel = full_hit ? full_idx : part_idx;
  assign pick_k   = full_hit ? KW'(N) : (part_hit ? KW'(fcount[part_idx]) : '0);
  assign cur_sel  = (slot_q == '0) ? pick_sel : sel_q;
  assign cur_k    = (slot_q == '0) ? pick_k : k_q;

  assign slot_idx  = slot_q;
  assign out_valid = int'(slot_q) < int'(cur_k);
  assign out_dest  = cur_sel;
  assign out_port  = port_q[cur_sel];
  assign out_data  = mem[cur_sel][rd_q[cur_sel]];
  assign in_ready  = (int'(in_dest) < N) && (int'(fcount[in_dest]) < DEPTH);

  always_comb begin
    for (int f = 0; f < N; f++) begin
      push_v[f] = in_valid && in_ready && (int'(in_dest) == f);
      pop_v[f]  = out_valid && (int'(cur_sel) == f);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      rr_q   <= '0;
      sel_q  <= '0;
      k_q    <= '0;
    end else begin
      slot_q <= (int'(slot_q) == N - 1) ? '0 : slot_q + 1'b1;
      if (slot_q == '0) begin
        sel_q <= pick_sel;
        k_q   <= pick_k;
        if (part_hit)
          rr_q <= (int'(pick_sel) == N - 1) ? '0 : pick_sel + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int f = 0; f < N; f++) begin
      if (!rst_n) begin
        wr_q[f]   <= '0;
        rd_q[f]   <= '0;
        fcount[f] <= '0;
        port_q[f] <= '0;
      end else begin
        fcount[f] <= fcount[f] + CW'(push_v[f]) - CW'(pop_v[f]);
        if (push_v[f])
          wr_q[f] <= (int'(wr_q[f]) == DEPTH - 1) ? '0 : wr_q[f] + 1'b1;
        if (pop_v[f]) begin
          rd_q[f]   <= (int'(rd_q[f]) == DEPTH - 1) ? '0 : rd_q[f] + 1'b1;
          port_q[f] <= (int'(port_q[f]) == N - 1) ? '0 : port_q[f] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int f = 0; f < N; f++)
      if (push_v[f]) mem[f][wr_q[f]] <= in_data;
  end

  assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_q) == N - 1 |=> slot_q == '0);

  assert_frame_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && slot_q != '0 |-> $past(out_valid) && out_dest == $past(out_dest));

  assert_port_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && slot_q != '0 |->
      int'(out_port) == (int'($past(out_port)) + 1) % N);

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fcount[g]) <= DEPTH);
    assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_ready && int'(in_dest) == g && !pop_v[g] |=>
        fcount[g] == $past(fcount[g]));
  end
endmodule

// File: tb/ffs_spreader_tb.sv
module ffs_spreader_tb;
  localparam int N = 4;
  localparam int DEPTH = 6;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_dest = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [1:0] slot_idx, out_dest, out_port;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  ffs_spreader #(.N(N), .DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .in_ready(in_ready), .slot_idx(slot_idx),
    .out_valid(out_valid), .out_data(out_data), .out_dest(out_dest),
    .out_port(out_port));

  int total = 0, bad = 0;
  int mq [N][DEPTH];
  int mc [N];
  int mp [N];
  int m_rr = 0, m_slot = 0, m_sel = 0, m_k = 0;
  bit m_full = 0;
  int tag = 0;
  int n_full = 0, n_part = 0, n_idle = 0, n_rej = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int d);
    bit er, ev;
    in_valid = v;
    in_dest  = 2'(d);
    in_data  = DW'(tag);
    #1;
    if (m_slot == 0) begin
      m_full = 0; m_k = 0;
      for (int j = 0; j < N; j++) begin
        int f = (m_rr + j) % N;
        if (!m_full && mc[f] >= N) begin m_full = 1; m_sel = f; m_k = N; end
      end
      if (!m_full)
        for (int j = N - 1; j >= 0; j--) begin
          int f = (m_rr + j) % N;
          if (mc[f] > 0) begin m_sel = f; m_k = mc[f]; end
        end
      if (m_full) n_full++; else if (m_k > 0) n_part++; else n_idle++;
      if (m_k > 0) m_rr = (m_sel + 1) % N;
    end
    ev = m_slot < m_k;
    er = mc[d] < DEPTH;
    chk(int'(slot_idx) == m_slot, "R1 slot_idx", int'(slot_idx), m_slot);
    chk(in_ready == er, "R3 in_ready", int'(in_ready), int'(er));
    chk(out_valid == ev, m_full ? "R4 out_valid" : "R5 out_valid", int'(out_valid), int'(ev));
    if (ev && out_valid) begin
      chk(int'(out_dest) == m_sel, "R6 R8 out_dest", int'(out_dest), m_sel);
      chk(int'(out_data) == (mq[m_sel][0] & 255), "R2 out_data", int'(out_data), mq[m_sel][0] & 255);
      chk(int'(out_port) == mp[m_sel], "R7 out_port", int'(out_port), mp[m_sel]);
    end
    if (ev) begin
      for (int i = 0; i < DEPTH - 1; i++) mq[m_sel][i] = mq[m_sel][i + 1];
      mc[m_sel]--;
      mp[m_sel] = (mp[m_sel] + 1) % N;
    end
    if (v && !er) n_rej++;
    if (v && er) begin
      mq[d][mc[d]] = tag;
      mc[d]++;
      tag++;
    end
    m_slot = (m_slot + 1) % N;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    for (int f = 0; f < N; f++) begin mc[f] = 0; mp[f] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    chk(slot_idx == 2'd0, "R9 slot_idx", int'(slot_idx), 0);
    chk(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) cyc(0, 0);
    for (int i = 0; i < 9; i++) cyc(1, 2);
    for (int i = 0; i < 40; i++) cyc(0, 0);
    for (int i = 0; i < 1500; i++) cyc(($urandom % 8) != 0, $urandom % N);
    for (int i = 0; i < 800; i++) cyc(($urandom % 4) == 0, $urandom % N);
    for (int i = 0; i < 800; i++) cyc(1, (($urandom % 4) != 0) ? 1 : $urandom % N);
    for (int i = 0; i < 600; i++) cyc(($urandom % 2) == 0, (i / 37) % N);
    for (int i = 0; i < 200; i++) cyc(0, 0);
    chk(n_full > 0, "R4 coverage", n_full, 1);
    chk(n_part > 0, "R5 coverage", n_part, 1);
    chk(n_idle > 0, "R6 idle coverage", n_idle, 1);
    chk(n_rej > 0, "R3 reject coverage", n_rej, 1);
    for (int f = 0; f < N; f++) chk(mc[f] == 0, "R2 drained", mc[f], 0);
    chk(out_valid == 1'b0, "R5 drained out_valid", int'(out_valid), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule